// File: doc/BRIEF.md
# Strobe-Counted Power Mode Sequencer

This block follows and commands the power state of a sampling converter. The state is one of three: operational, nap or sleep. Software never writes it. The state is chosen by counting rising edges of the convert strobe that arrive while the serial clock stays idle. During normal conversions the serial clock toggles every frame, so the count never gets far. When a host stops the serial clock and keeps pulsing the strobe, the block steps into nap and then into sleep.

Both inputs are treated as asynchronous. Each one passes through a synchronizer and a rising-edge detector before the state machine sees it. A rising edge of the serial clock clears the strobe count and wakes the block. The exception is sleep when the I/O mode select is set to LVDS: there the serial clock is ignored, and only the fifth strobe leaves sleep.

Any exit from sleep starts a settling timer whose length is set by a parameter. The ready output stays low until the timer has run out. The states are `PS_RUN` (operational), `PS_NAP` and `PS_SLEEP`. The transitions are:
- strobe count reaches 2: RUN to NAP
- strobe count reaches 3: NAP to RUN
- strobe count reaches 4: RUN to SLEEP
- strobe count reaches 5: SLEEP to RUN, and the count restarts
- serial-clock rise: NAP to RUN
- serial-clock rise in CMOS mode: SLEEP to RUN

Top module: `strobe_power_seq`

## Requirements
- R1: After reset the state is operational, `ready` is 1, `settle_busy` is 0 and the strobe count is zero.
- R2: `pwr_state` uses the code 2'b00 for operational, 2'b01 for nap and 2'b10 for sleep; 2'b11 never appears.
- R3: The second strobe rising edge counted since reset, since the last accepted serial-clock rise, or since the last wrap moves the state from operational to nap. The first edge leaves the state unchanged.
- R4: The third strobe rising edge in that count moves the state from nap back to operational.
- R5: The fourth strobe rising edge moves the state from operational to sleep.
- R6: The fifth strobe rising edge leaves sleep for operational in either I/O mode and returns the count to zero. With no serial-clock activity, strobes therefore cycle through operational, nap and sleep with period five.
- R7: In operational or nap, a serial-clock rising edge clears the strobe count, and in nap it also returns the state to operational. This holds in both I/O modes.
- R8: With `lvds_mode` = 0 (CMOS), a serial-clock rising edge in sleep returns the state to operational.
- R9: With `lvds_mode` = 1 (LVDS), a serial-clock rising edge in sleep changes neither the state nor the strobe count, so a single further strobe still leaves sleep.
- R10: Every exit from sleep loads the settling timer with `SETTLE_CYCLES`. `settle_busy` is 1 and `ready` is 0 until the timer reaches zero, and `ready` is 1 after that.
- R11: `ready` is 0 whenever the state is nap or sleep.
- R12: A strobe held high for many cycles counts as one edge. Only a new rising edge advances the count.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cnv_strobe | input | 1 | Convert strobe, asynchronous |
| ser_clk | input | 1 | Serial data clock, asynchronous |
| lvds_mode | input | 1 | I/O mode select: 0 CMOS, 1 LVDS |
| pwr_state | output | 2 | Current power state code |
| ready | output | 1 | Operational and settled |
| settle_busy | output | 1 | Post-sleep settling timer running |

## Verification
The bench checks the count boundaries: the first strobe must not trigger nap, the third must wake from nap, and the fifth must wrap the count. A counter that is off by one, or one that saturates, would drift out of the period-five cycle, and repeated strobes in both modes expose that.

The serial clock in LVDS sleep is a separate target. If a design cleared the count there, it would need five more strobes to wake instead of one. If it woke on that edge, it would behave like CMOS mode.

A strobe held high over many cycles catches a level-sensitive counter, which would keep counting. Checking the settling window right after a sleep exit catches a design that raises `ready` too early.

// File: rtl/pwr_seq_pkg.sv
package pwr_seq_pkg;

    typedef enum logic [1:0] {
        PS_RUN   = 2'b00,
        PS_NAP   = 2'b01,
        PS_SLEEP = 2'b10
    } pwr_state_e;

    // strobe counts at which the state machine acts; the order is behaviour
    localparam int unsigned NAP_AT   = 2;
    localparam int unsigned WAKE_AT  = 3;
    localparam int unsigned SLEEP_AT = 4;
    localparam int unsigned EXIT_AT  = 5;

endpackage

// File: rtl/edge_sync.sv
module edge_sync #(
    parameter int unsigned STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic din,
    output logic rise
);
    logic [STAGES-1:0] chain;
    logic              last;

    generate
        if (STAGES == 1) begin : g_single
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) chain <= '0;
                else        chain <= din;
            end
        end else begin : g_multi
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) chain <= '0;
                else        chain <= {chain[STAGES-2:0], din};
            end
        end
    endgenerate

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) last <= 1'b0;
        else        last <= chain[STAGES-1];
    end

    assign rise = chain[STAGES-1] & ~last;
endmodule

// File: rtl/strobe_tally.sv
module strobe_tally #(
    parameter int unsigned LIMIT = 5,
    localparam int unsigned W    = $clog2(LIMIT + 1)
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         clear,
    input  logic         bump,
    output logic [W-1:0] count
);
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            count <= '0;
        end else if (clear) begin
            count <= '0;
        end else if (bump) begin
            if (count == W'(LIMIT - 1)) count <= '0;
            else                        count <= count + W'(1);
        end
    end
endmodule

// File: rtl/settle_timer.sv
module settle_timer #(
    parameter int unsigned CYCLES = 500000,
    localparam int unsigned TW    = $clog2(CYCLES + 1)
) (
    input  logic clk,
    input  logic rst_n,
    input  logic load,
    output logic busy
);
    logic [TW-1:0] remaining;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            remaining <= '0;
        end else if (load) begin
            remaining <= TW'(CYCLES);
        end else if (remaining != '0) begin
            remaining <= remaining - TW'(1);
        end
    end

    assign busy = (remaining != '0);
endmodule

// File: rtl/strobe_power_seq.sv
module strobe_power_seq
    import pwr_seq_pkg::*;
#(
    parameter int unsigned SYNC_STAGES   = 2,
    parameter int unsigned SETTLE_CYCLES = 500000
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       cnv_strobe,
    input  logic       ser_clk,
    input  logic       lvds_mode,
    output logic [1:0] pwr_state,
    output logic       ready,
    output logic       settle_busy
);
    localparam int unsigned CW = $clog2(EXIT_AT + 1);

    logic          strobe_rise;
    logic          sclk_rise;
    logic          sclk_ignored;
    logic          cnt_clear;
    logic          cnt_bump;
    logic          settle_load;
    logic [CW-1:0] cnt_q;
    logic [CW-1:0] cnt_after;
    pwr_state_e    state_q;
    pwr_state_e    state_d;

    edge_sync #(.STAGES(SYNC_STAGES)) u_strobe_sync (
        .clk  (clk),
        .rst_n(rst_n),
        .din  (cnv_strobe),
        .rise (strobe_rise)
    );

    edge_sync #(.STAGES(SYNC_STAGES)) u_sclk_sync (
        .clk  (clk),
        .rst_n(rst_n),
        .din  (ser_clk),
        .rise (sclk_rise)
    );

    strobe_tally #(.LIMIT(EXIT_AT)) u_tally (
        .clk  (clk),
        .rst_n(rst_n),
        .clear(cnt_clear),
        .bump (cnt_bump),
        .count(cnt_q)
    );

    settle_timer #(.CYCLES(SETTLE_CYCLES)) u_settle (
        .clk  (clk),
        .rst_n(rst_n),
        .load (settle_load),
        .busy (settle_busy)
    );

    assign cnt_after    = cnt_q + CW'(1);
    assign sclk_ignored = lvds_mode && (state_q == PS_SLEEP);

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= PS_RUN;
        else        state_q <= state_d;
    end

    // next state and counter / timer commands
    always_comb begin
        state_d     = state_q;
        cnt_clear   = 1'b0;
        cnt_bump    = 1'b0;
        settle_load = 1'b0;
        if (sclk_rise && !sclk_ignored) begin
            cnt_clear = 1'b1;
            unique case (state_q)
                PS_RUN:   state_d = PS_RUN;
                PS_NAP:   state_d = PS_RUN;
                PS_SLEEP: begin
                    state_d     = PS_RUN;
                    settle_load = 1'b1;
                end
                default:  state_d = PS_RUN;
            endcase
        end else if (strobe_rise) begin
            cnt_bump = 1'b1;
            unique case (cnt_after)
                CW'(NAP_AT):   state_d = PS_NAP;
                CW'(WAKE_AT):  state_d = PS_RUN;
                CW'(SLEEP_AT): state_d = PS_SLEEP;
                CW'(EXIT_AT):  begin
                    state_d     = PS_RUN;
                    settle_load = 1'b1;
                end
                default:       state_d = state_q;
            endcase
        end
    end

    // outputs
    always_comb begin
        pwr_state = state_q;
        ready     = (state_q == PS_RUN) && !settle_busy;
    end
endmodule

// File: rtl/pwr_seq_checker.sv
module pwr_seq_checker
    import pwr_seq_pkg::*;
(
    input logic       clk,
    input logic       rst_n,
    input logic       lvds_mode,
    input logic       sclk_rise,
    input logic       strobe_rise,
    input logic [1:0] pwr_state,
    input logic       ready,
    input logic       settle_busy
);
    logic primed;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) primed <= 1'b0;
        else        primed <= 1'b1;
    end

    assert_legal_code_R2: assert property (@(posedge clk) disable iff (!rst_n)
        pwr_state != 2'b11);

    assert_nap_from_run_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (primed && pwr_state == PS_NAP && $past(pwr_state) != PS_NAP)
        |-> $past(pwr_state) == PS_RUN);

    assert_sleep_from_run_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (primed && pwr_state == PS_SLEEP && $past(pwr_state) != PS_SLEEP)
        |-> $past(pwr_state) == PS_RUN);

    assert_sclk_wakes_nap_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (pwr_state == PS_NAP && sclk_rise) |=> pwr_state == PS_RUN);

    assert_lvds_sleep_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (lvds_mode && pwr_state == PS_SLEEP && sclk_rise && !strobe_rise)
        |=> pwr_state == PS_SLEEP);

    assert_settle_start_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (primed && $rose(settle_busy))
        |-> ($past(pwr_state) == PS_SLEEP && pwr_state == PS_RUN));

    assert_exit_not_ready_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (primed && $past(pwr_state) == PS_SLEEP && pwr_state == PS_RUN)
        |-> (settle_busy && !ready));

    assert_ready_low_idle_R11: assert property (@(posedge clk) disable iff (!rst_n)
        (primed && $past(pwr_state) == PS_RUN && pwr_state == PS_NAP) |-> !ready);
endmodule

bind strobe_power_seq pwr_seq_checker u_pwr_seq_checker (
    .clk        (clk),
    .rst_n      (rst_n),
    .lvds_mode  (lvds_mode),
    .sclk_rise  (sclk_rise),
    .strobe_rise(strobe_rise),
    .pwr_state  (pwr_state),
    .ready      (ready),
    .settle_busy(settle_busy)
);

// File: tb/tb_strobe_power_seq.sv
module tb_strobe_power_seq;
    localparam int unsigned SETTLE = 40;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       cnv_strobe = 1'b0;
    logic       ser_clk = 1'b0;
    logic       lvds_mode = 1'b0;
    logic [1:0] pwr_state;
    logic       ready;
    logic       settle_busy;

    int checks = 0;
    int fails  = 0;
    bit done   = 1'b0;

    // model state: 0 run, 1 nap, 2 sleep
    logic [1:0] m_st  = 2'd0;
    int         m_cnt = 0;

    always #10 clk = ~clk;

    strobe_power_seq #(.SYNC_STAGES(2), .SETTLE_CYCLES(SETTLE)) dut (
        .clk        (clk),
        .rst_n      (rst_n),
        .cnv_strobe (cnv_strobe),
        .ser_clk    (ser_clk),
        .lvds_mode  (lvds_mode),
        .pwr_state  (pwr_state),
        .ready      (ready),
        .settle_busy(settle_busy)
    );

    task automatic check(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic tick(input int n);
        repeat (n) @(negedge clk);
    endtask

    // expected state/count after one event (sclk=1: serial-clock rise)
    function automatic logic [1:0] next_state(input logic [1:0] st, input int cnt,
                                              input bit sclk, input bit lvds);
        if (sclk) begin
            if (lvds && st == 2'd2) return st;
            return 2'd0;
        end
        case (cnt + 1)
            2:       return 2'd1;
            3:       return 2'd0;
            4:       return 2'd2;
            5:       return 2'd0;
            default: return st;
        endcase
    endfunction

    function automatic int next_count(input logic [1:0] st, input int cnt,
                                      input bit sclk, input bit lvds);
        if (sclk) begin
            if (lvds && st == 2'd2) return cnt;
            return 0;
        end
        return (cnt + 1) % 5;
    endfunction

    task automatic strobe(input int hold);
        m_st_update(1'b0);
        @(negedge clk) cnv_strobe = 1'b1;
        tick(hold);
        cnv_strobe = 1'b0;
        tick(5);
    endtask

    task automatic sclk_pulse();
        m_st_update(1'b1);
        @(negedge clk) ser_clk = 1'b1;
        tick(3);
        ser_clk = 1'b0;
        tick(5);
    endtask

    task automatic m_st_update(input bit sclk);
        logic [1:0] ns;
        ns    = next_state(m_st, m_cnt, sclk, lvds_mode);
        m_cnt = next_count(m_st, m_cnt, sclk, lvds_mode);
        m_st  = ns;
    endtask

    initial begin : watchdog
        repeat (150000) @(posedge clk);
        if (!done) begin
            checks++;
            fails++;
            $display("FAIL watchdog: actual running expected finished");
            $display("%0d/%0d checks passed", checks - fails, checks);
            $finish;
        end
    end

    initial begin : stim
        void'($urandom(32'd20240611));
        tick(4);
        check("R1 reset state", pwr_state, 0);
        check("R1 reset ready", ready, 1);
        check("R1 reset busy", settle_busy, 0);
        rst_n = 1'b1;
        tick(3);

        // CMOS strobe ladder
        strobe(2); check("R3 first strobe stays run", pwr_state, 0);
        strobe(2); check("R3 second strobe nap", pwr_state, 1);
        check("R11 ready low in nap", ready, 0);
        check("R2 nap code", pwr_state, 2'b01);
        strobe(2); check("R4 third strobe wakes", pwr_state, 0);
        strobe(2); check("R5 fourth strobe sleep", pwr_state, 2);
        check("R11 ready low in sleep", ready, 0);
        strobe(2); check("R6 fifth strobe exits", pwr_state, 0);
        check("R10 busy after exit", settle_busy, 1);
        check("R10 ready low while settling", ready, 0);
        tick(SETTLE + 10);
        check("R10 ready after settle", ready, 1);
        check("R10 busy cleared", settle_busy, 0);

        // serial clock clears count and wakes nap
        strobe(2);
        sclk_pulse();
        strobe(2); check("R7 count cleared by sclk", pwr_state, 0);
        strobe(2); check("R7 nap reached", pwr_state, 1);
        sclk_pulse(); check("R7 sclk wakes nap", pwr_state, 0);

        // CMOS sleep exit by serial clock
        repeat (4) strobe(2);
        check("R5 sleep before cmos exit", pwr_state, 2);
        sclk_pulse(); check("R8 cmos sclk exits sleep", pwr_state, 0);
        check("R10 busy after sclk exit", settle_busy, 1);
        tick(SETTLE + 10);

        // LVDS sleep ignores serial clock
        lvds_mode = 1'b1;
        sclk_pulse();
        repeat (4) strobe(2);
        check("R5 lvds sleep", pwr_state, 2);
        sclk_pulse(); check("R9 lvds sclk ignored", pwr_state, 2);
        sclk_pulse(); check("R9 lvds sclk ignored again", pwr_state, 2);
        strobe(2); check("R9 one strobe exits lvds sleep", pwr_state, 0);
        tick(SETTLE + 10);

        // free-running cycle, period five
        for (int i = 1; i <= 10; i++) begin
            strobe(2);
            check($sformatf("R6 cycle strobe %0d", i), pwr_state, m_st);
        end
        tick(SETTLE + 10);

        // long strobe counts once
        lvds_mode = 1'b0;
        sclk_pulse();
        strobe(30); check("R12 held strobe counted once", pwr_state, 0);
        strobe(2);  check("R12 next edge reaches nap", pwr_state, 1);
        sclk_pulse();

        // constrained random events
        for (int k = 0; k < 400; k++) begin
            lvds_mode = ($urandom_range(0, 3) == 0);
            if ($urandom_range(0, 9) < 7) strobe($urandom_range(2, 6));
            else                          sclk_pulse();
            check($sformatf("R3 R4 R5 R6 R7 R8 R9 random state %0d", k), pwr_state, m_st);
            if (m_st != 2'd0) check("R11 random ready low", ready, 0);
        end

        done = 1'b1;
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end
endmodule